// File: doc/BRIEF.md
# Receive Lane Framing Checker

This block sits behind the symbol decoders of a multi-lane serial receiver. Each clock it may receive one lane group: one decoded byte and a control-symbol (K) flag per lane, plus per-lane decode-error and running-disparity-error flags. It checks the group against the physical-layer framing rules. It tracks whether a packet is open and whether the previous group was logical idle, and it raises a framing-error pulse for any group that breaks a rule.

Each time a packet-end symbol arrives, the block issues a three-way packet verdict: ACK, NAK for a framing problem, or plain NAK for a symbol-level error. It also reports the lanes that carried the last start and the last end symbol in the group. When a new packet starts in the same group after an earlier end, it flags a back-to-back packet. Lanes are evaluated in ascending order, so a packet may close and another may open within one group.

Top module: `rx_frame_checker`

## Requirements
- R1: When `rst` or a low `link_up` is sampled at a clock edge, the block clears its state: no packet open, no pending framing or NAK cause, and no idle history. Every output is low after that edge. All outputs are registered and reflect the group presented one clock earlier.
- R2: A start symbol is K=1 with byte 0xFB or 0x5C. A start symbol on a lane whose index is not a multiple of 4 raises `frame_err`. A start symbol always opens a packet.
- R3: A group is logical idle when at least `IDLE_ZERO_MIN` of its lanes carry the non-K byte 0x00. In the next valid group, a start symbol on any lane other than lane 0 raises `frame_err`.
- R4: A start symbol while a packet is already open raises `frame_err`.
- R5: An end symbol is K=1 with byte 0xFD or 0xFE. An end symbol on lane i where i+1 is not a multiple of 4 raises `frame_err`.
- R6: An end symbol that is not on the last lane must be followed on the next lane by a K symbol with byte 0xF7 (pad), 0xFB or 0x5C. Any other next-lane symbol raises `frame_err`.
- R7: An end symbol with no packet open raises `frame_err`. An end symbol always closes the packet.
- R8: A comma symbol (K=1, byte 0xBC) while a packet is open raises `frame_err`.
- R9: Every end symbol produces `verdict_valid` with a code in `verdict`. The code is 01 if any framing violation occurred since the previous verdict, counting the end lane's own checks. Otherwise it is 10 if any `dec_err` or `disp_err` lane flag was set in that span. Otherwise it is 00. Both causes clear once the verdict is issued.
- R10: `start_seen`/`start_lane` give the highest lane in the group that carries a start symbol. `end_seen`/`end_lane` do the same for end symbols. `back_to_back` is high when both are seen and the start lane is above the end lane.
- R11: A cycle with `grp_valid` low changes no state and gives all-low outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link trained; low suppresses checks and clears state |
| grp_valid | input | 1 | A lane group is present this cycle |
| sym_data | input | NUM_LANES*8 | Decoded bytes, lane i at bits [8i+7:8i] |
| sym_k | input | NUM_LANES | Control-symbol flag per lane |
| dec_err | input | NUM_LANES | 8b/10b decode error per lane |
| disp_err | input | NUM_LANES | Running-disparity error per lane |
| frame_err | output | 1 | Group broke a framing rule |
| verdict_valid | output | 1 | A packet ended in the group |
| verdict | output | 2 | 00 ACK, 01 NAK framing, 10 NAK |
| start_seen | output | 1 | Group held a start symbol |
| start_lane | output | $clog2(NUM_LANES) | Highest lane with a start symbol |
| end_seen | output | 1 | Group held an end symbol |
| end_lane | output | $clog2(NUM_LANES) | Highest lane with an end symbol |
| back_to_back | output | 1 | Start lane above end lane in one group |

## Verification
A wrong open-packet bit shows up at the ports in the next group that holds a start, end or comma symbol: `frame_err` appears where none is expected, or goes missing. A stale framing or NAK cause shows as a wrong `verdict` code, but only at the next end symbol, which may be many groups later. A bad idle history shows only when a start symbol lands on a lane other than 0. Directed groups therefore place each case right after the state it depends on, and long random runs with idle groups, gaps and link drops compare every output against a model on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [7:0] SYM_STP = 8'hFB;
  localparam logic [7:0] SYM_SDP = 8'h5C;
  localparam logic [7:0] SYM_END = 8'hFD;
  localparam logic [7:0] SYM_EDB = 8'hFE;
  localparam logic [7:0] SYM_PAD = 8'hF7;
  localparam logic [7:0] SYM_COM = 8'hBC;

  typedef enum logic [1:0] {
    VD_ACK     = 2'b00,
    VD_NAK_FRM = 2'b01,
    VD_NAK     = 2'b10
  } verdict_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic comma;
    logic follow_ok;
    logic zero;
  } lane_cls_t;
endpackage

// File: rtl/rxf_lane_decode.sv
module rxf_lane_decode
  import rxf_pkg::*;
(
  input  logic [7:0] sym_i,
  input  logic       k_i,
  output lane_cls_t  cls_o
);
  always_comb begin
    cls_o.start     = k_i && (sym_i == SYM_STP || sym_i == SYM_SDP);
    cls_o.stop      = k_i && (sym_i == SYM_END || sym_i == SYM_EDB);
    cls_o.comma     = k_i && (sym_i == SYM_COM);
    cls_o.follow_ok = k_i && (sym_i == SYM_PAD || sym_i == SYM_STP || sym_i == SYM_SDP);
    cls_o.zero      = !k_i && (sym_i == 8'h00);
  end
endmodule

// File: rtl/rxf_idle_detect.sv
module rxf_idle_detect #(
  parameter int NUM_LANES     = 8,
  parameter int IDLE_ZERO_MIN = NUM_LANES
) (
  input  logic [NUM_LANES-1:0] zero_i,
  output logic                 idle_o
);
  localparam int CW = $clog2(NUM_LANES + 1);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_LANES; i++) cnt = cnt + CW'(zero_i[i]);
    idle_o = (32'(cnt) >= IDLE_ZERO_MIN);
  end
endmodule

// File: rtl/rxf_frame_rules.sv
module rxf_frame_rules
  import rxf_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int LW        = $clog2(NUM_LANES)
) (
  input  lane_cls_t             cls_i [NUM_LANES],
  input  logic [NUM_LANES-1:0]  lane_err_i,
  input  logic                  open_i,
  input  logic                  ferr_i,
  input  logic                  nak_i,
  input  logic                  prev_idle_i,
  output logic                  open_o,
  output logic                  ferr_o,
  output logic                  nak_o,
  output logic                  viol_o,
  output logic                  vval_o,
  output verdict_t              verdict_o,
  output logic                  sseen_o,
  output logic [LW-1:0]         slane_o,
  output logic                  eseen_o,
  output logic [LW-1:0]         elane_o
);
  logic [NUM_LANES-1:0] nxt_ok;
  logic                 bad;

  // Lane after each lane must be pad or a start symbol; the last lane has no neighbour
  for (genvar g = 0; g < NUM_LANES - 1; g++) begin : g_next
    assign nxt_ok[g] = cls_i[g+1].follow_ok;
  end
  assign nxt_ok[NUM_LANES-1] = 1'b1;

  always_comb begin
    open_o    = open_i;
    ferr_o    = ferr_i;
    nak_o     = nak_i;
    viol_o    = 1'b0;
    vval_o    = 1'b0;
    verdict_o = VD_ACK;
    sseen_o   = 1'b0;
    slane_o   = '0;
    eseen_o   = 1'b0;
    elane_o   = '0;
    bad       = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      bad = 1'b0;
      if (lane_err_i[i]) nak_o = 1'b1;
      if (cls_i[i].start) begin
        if ((i % 4) != 0)            bad = 1'b1;
        if (prev_idle_i && (i != 0)) bad = 1'b1;
        if (open_o)                  bad = 1'b1;
        open_o  = 1'b1;
        sseen_o = 1'b1;
        slane_o = LW'(i);
      end
      if (cls_i[i].stop) begin
        if (((i + 1) % 4) != 0) bad = 1'b1;
        if (!nxt_ok[i])         bad = 1'b1;
        if (!open_o)            bad = 1'b1;
      end
      if (cls_i[i].comma && open_o) bad = 1'b1;
      if (bad) begin
        ferr_o = 1'b1;
        viol_o = 1'b1;
      end
      if (cls_i[i].stop) begin
        vval_o    = 1'b1;
        verdict_o = ferr_o ? VD_NAK_FRM : (nak_o ? VD_NAK : VD_ACK);
        ferr_o    = 1'b0;
        nak_o     = 1'b0;
        open_o    = 1'b0;
        eseen_o   = 1'b1;
        elane_o   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rxf_pkg::*;
#(
  parameter int NUM_LANES     = 8,
  parameter int IDLE_ZERO_MIN = NUM_LANES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         link_up,
  input  logic                         grp_valid,
  input  logic [NUM_LANES*8-1:0]       sym_data,
  input  logic [NUM_LANES-1:0]         sym_k,
  input  logic [NUM_LANES-1:0]         dec_err,
  input  logic [NUM_LANES-1:0]         disp_err,
  output logic                         frame_err,
  output logic                         verdict_valid,
  output logic [1:0]                   verdict,
  output logic                         start_seen,
  output logic [$clog2(NUM_LANES)-1:0] start_lane,
  output logic                         end_seen,
  output logic [$clog2(NUM_LANES)-1:0] end_lane,
  output logic                         back_to_back
);
  localparam int LANE_W = $clog2(NUM_LANES);

  lane_cls_t            cls [NUM_LANES];
  logic [NUM_LANES-1:0] zero_vec;
  logic                 grp_idle;

  logic open_q, ferr_q, nak_q, idle_q;
  logic open_n, ferr_n, nak_n, viol_n, vval_n, sseen_n, eseen_n;
  verdict_t             verdict_n;
  logic [LANE_W-1:0]    slane_n, elane_n;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rxf_lane_decode u_dec (
      .sym_i (sym_data[g*8 +: 8]),
      .k_i   (sym_k[g]),
      .cls_o (cls[g])
    );
    assign zero_vec[g] = cls[g].zero;
  end

  rxf_idle_detect #(
    .NUM_LANES     (NUM_LANES),
    .IDLE_ZERO_MIN (IDLE_ZERO_MIN)
  ) u_idle (
    .zero_i (zero_vec),
    .idle_o (grp_idle)
  );

  rxf_frame_rules #(
    .NUM_LANES (NUM_LANES),
    .LW        (LANE_W)
  ) u_rules (
    .cls_i       (cls),
    .lane_err_i  (dec_err | disp_err),
    .open_i      (open_q),
    .ferr_i      (ferr_q),
    .nak_i       (nak_q),
    .prev_idle_i (idle_q),
    .open_o      (open_n),
    .ferr_o      (ferr_n),
    .nak_o       (nak_n),
    .viol_o      (viol_n),
    .vval_o      (vval_n),
    .verdict_o   (verdict_n),
    .sseen_o     (sseen_n),
    .slane_o     (slane_n),
    .eseen_o     (eseen_n),
    .elane_o     (elane_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      open_q <= 1'b0;
      ferr_q <= 1'b0;
      nak_q  <= 1'b0;
      idle_q <= 1'b0;
    end else if (grp_valid) begin
      open_q <= open_n;
      ferr_q <= ferr_n;
      nak_q  <= nak_n;
      idle_q <= grp_idle;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !link_up || !grp_valid) begin
      frame_err     <= 1'b0;
      verdict_valid <= 1'b0;
      verdict       <= VD_ACK;
      start_seen    <= 1'b0;
      start_lane    <= '0;
      end_seen      <= 1'b0;
      end_lane      <= '0;
      back_to_back  <= 1'b0;
    end else begin
      frame_err     <= viol_n;
      verdict_valid <= vval_n;
      verdict       <= verdict_n;
      start_seen    <= sseen_n;
      start_lane    <= slane_n;
      end_seen      <= eseen_n;
      end_lane      <= elane_n;
      back_to_back  <= sseen_n && eseen_n && (slane_n > elane_n);
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          link_up,
  input logic          grp_valid,
  input logic          frame_err,
  input logic          verdict_valid,
  input logic [1:0]    verdict,
  input logic          start_seen,
  input logic [LW-1:0] start_lane,
  input logic          end_seen,
  input logic [LW-1:0] end_lane,
  input logic          back_to_back
);
  a_r1_quiet_after_down: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (!frame_err && !verdict_valid && !start_seen && !end_seen && !back_to_back));

  a_r11_quiet_on_gap: assert property (@(posedge clk) disable iff (rst)
    !grp_valid |=> (!frame_err && !verdict_valid && !back_to_back));

  a_r9_code_legal: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> (verdict != 2'b11));

  a_r9_verdict_with_end: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> end_seen);

  a_r10_b2b_order: assert property (@(posedge clk) disable iff (rst)
    back_to_back |-> (start_seen && end_seen && (start_lane > end_lane)));
endmodule

bind rx_frame_checker rxf_checker #(.LW(LANE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .link_up       (link_up),
  .grp_valid     (grp_valid),
  .frame_err     (frame_err),
  .verdict_valid (verdict_valid),
  .verdict       (verdict),
  .start_seen    (start_seen),
  .start_lane    (start_lane),
  .end_seen      (end_seen),
  .end_lane      (end_lane),
  .back_to_back  (back_to_back)
);

// File: tb/rx_frame_checker_test.sv
module rx_frame_checker_test;
  localparam int NL = 8;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            link_up = 1'b0;
  logic            grp_valid = 1'b0;
  logic [NL*8-1:0] sym_data = '0;
  logic [NL-1:0]   sym_k = '0;
  logic [NL-1:0]   dec_err = '0;
  logic [NL-1:0]   disp_err = '0;
  logic            frame_err, verdict_valid, start_seen, end_seen, back_to_back;
  logic [1:0]      verdict;
  logic [LW-1:0]   start_lane, end_lane;

  always #2.5 clk = ~clk;

  rx_frame_checker #(.NUM_LANES(NL)) uut (
    .clk(clk), .rst(rst), .link_up(link_up), .grp_valid(grp_valid),
    .sym_data(sym_data), .sym_k(sym_k), .dec_err(dec_err), .disp_err(disp_err),
    .frame_err(frame_err), .verdict_valid(verdict_valid), .verdict(verdict),
    .start_seen(start_seen), .start_lane(start_lane), .end_seen(end_seen),
    .end_lane(end_lane), .back_to_back(back_to_back)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state and expectations
  int m_open = 0, m_ferr = 0, m_nak = 0, m_idle = 0;
  int e_fe, e_vv, e_vd, e_ss, e_sl, e_es, e_el, e_bb;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_k(input int i, input logic [7:0] v);
    return sym_k[i] && sym_data[i*8 +: 8] == v;
  endfunction

  task automatic model_step();
    int zeros, op, fe, nk, bad;
    e_fe = 0; e_vv = 0; e_vd = 0; e_ss = 0; e_sl = 0; e_es = 0; e_el = 0; e_bb = 0;
    if (rst || !link_up) begin
      m_open = 0; m_ferr = 0; m_nak = 0; m_idle = 0;
      return;
    end
    if (!grp_valid) return;
    zeros = 0; op = m_open; fe = m_ferr; nk = m_nak;
    for (int i = 0; i < NL; i++) begin
      bit st, en;
      if (!sym_k[i] && sym_data[i*8 +: 8] == 8'h00) zeros++;
      st = is_k(i, 8'hFB) || is_k(i, 8'h5C);
      en = is_k(i, 8'hFD) || is_k(i, 8'hFE);
      bad = 0;
      if (dec_err[i] || disp_err[i]) nk = 1;
      if (st) begin
        if (i % 4 != 0) bad = 1;
        if (m_idle != 0 && i != 0) bad = 1;
        if (op != 0) bad = 1;
        op = 1; e_ss = 1; e_sl = i;
      end
      if (en) begin
        if ((i + 1) % 4 != 0) bad = 1;
        if (i < NL - 1 && !(is_k(i+1, 8'hF7) || is_k(i+1, 8'hFB) || is_k(i+1, 8'h5C))) bad = 1;
        if (op == 0) bad = 1;
      end
      if (is_k(i, 8'hBC) && op != 0) bad = 1;
      if (bad != 0) begin fe = 1; e_fe = 1; end
      if (en) begin
        e_vv = 1;
        e_vd = (fe != 0) ? 1 : ((nk != 0) ? 2 : 0);
        fe = 0; nk = 0; op = 0; e_es = 1; e_el = i;
      end
    end
    e_bb = (e_ss != 0 && e_es != 0 && e_sl > e_el) ? 1 : 0;
    m_open = op; m_ferr = fe; m_nak = nk;
    m_idle = (zeros >= NL) ? 1 : 0;
  endtask

  task automatic compare_all();
    check("MODEL frame_err", frame_err, e_fe);
    check("MODEL verdict_valid", verdict_valid, e_vv);
    if (e_vv != 0) check("MODEL verdict", verdict, e_vd);
    check("MODEL start_seen", start_seen, e_ss);
    if (e_ss != 0) check("MODEL start_lane", start_lane, e_sl);
    check("MODEL end_seen", end_seen, e_es);
    if (e_es != 0) check("MODEL end_lane", end_lane, e_el);
    check("MODEL back_to_back", back_to_back, e_bb);
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic g_fill(input logic [7:0] v);
    for (int i = 0; i < NL; i++) begin
      sym_data[i*8 +: 8] = v; sym_k[i] = 1'b0;
    end
    dec_err = '0; disp_err = '0; grp_valid = 1'b1;
  endtask

  task automatic put_k(input int i, input logic [7:0] v);
    sym_data[i*8 +: 8] = v; sym_k[i] = 1'b1;
  endtask

  task automatic pads_from(input int i0);
    for (int i = i0; i < NL; i++) put_k(i, 8'hF7);
  endtask

  // STP lane0, data, END lane3, pads
  task automatic g_small_pkt();
    g_fill(8'h11); put_k(0, 8'hFB); put_k(3, 8'hFD); pads_from(4);
  endtask

  initial begin
    @(negedge clk);
    cycle(); cycle();
    check("R1 reset frame_err", frame_err, 0);
    check("R1 reset verdict_valid", verdict_valid, 0);
    rst = 1'b0; link_up = 1'b1;

    g_small_pkt(); cycle();
    check("R9 clean packet ACK", verdict, 0);
    check("R9 clean packet no frame_err", frame_err, 0);
    check("R10 start lane 0", start_lane, 0);
    check("R10 end lane 3", end_lane, 3);

    g_fill(8'h22); put_k(2, 8'hFB); cycle();
    check("R2 start on lane 2", frame_err, 1);
    g_fill(8'h11); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R2 start opened packet, END ok", frame_err, 0);
    check("R9 framing NAK code", verdict, 1);
    g_small_pkt(); cycle();
    check("R9 cause cleared after verdict", verdict, 0);

    g_fill(8'h00); cycle();
    check("R3 idle group no error", frame_err, 0);
    g_fill(8'h11); for (int i = 0; i < 4; i++) sym_data[i*8 +: 8] = 8'h00;
    put_k(4, 8'hFB); cycle();
    check("R3 start on lane 4 after idle", frame_err, 1);
    g_fill(8'h11); put_k(3, 8'hFE); pads_from(4); cycle();
    check("R3 packet verdict framing", verdict, 1);

    g_fill(8'h11); put_k(0, 8'h5C); put_k(4, 8'hFB); cycle();
    check("R4 start while open", frame_err, 1);
    g_fill(8'h11); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R4 verdict framing", verdict, 1);

    g_fill(8'h11); put_k(0, 8'hFB); put_k(2, 8'hFD); pads_from(3); cycle();
    check("R5 end on lane 2", frame_err, 1);
    check("R5 end lane reported", end_lane, 2);

    g_small_pkt(); sym_data[4*8 +: 8] = 8'h33; sym_k[4] = 1'b0; cycle();
    check("R6 end followed by data", frame_err, 1);
    check("R6 verdict framing", verdict, 1);

    g_fill(8'h44); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R7 end with nothing open", frame_err, 1);
    check("R7 verdict issued", verdict_valid, 1);

    g_fill(8'h11); put_k(0, 8'hFB); put_k(5, 8'hBC); cycle();
    check("R8 comma inside packet", frame_err, 1);
    g_fill(8'h11); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R8 verdict framing", verdict, 1);

    g_small_pkt(); dec_err[1] = 1'b1; cycle();
    check("R9 decode error gives NAK", verdict, 2);
    check("R9 decode error no frame_err", frame_err, 0);
    g_fill(8'h11); put_k(0, 8'hFB); put_k(2, 8'hFD); pads_from(3); disp_err[1] = 1'b1; cycle();
    check("R9 framing wins over disparity", verdict, 1);

    g_fill(8'h11); put_k(0, 8'hFB); cycle();
    g_fill(8'h11); put_k(3, 8'hFD); put_k(4, 8'hFB); cycle();
    check("R10 back_to_back set", back_to_back, 1);
    check("R10 start lane 4", start_lane, 4);
    check("R10 b2b no frame_err", frame_err, 0);
    g_fill(8'h11); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R10 back_to_back clear", back_to_back, 0);
    check("R10 second packet ACK", verdict, 0);

    g_fill(8'h11); put_k(2, 8'hFB); grp_valid = 1'b0; cycle();
    check("R11 gap quiet", frame_err, 0);
    g_small_pkt(); cycle();
    check("R11 gap left no packet open", frame_err, 0);

    g_fill(8'h11); put_k(0, 8'hFB); cycle();
    link_up = 1'b0; cycle();
    check("R1 link down quiet", verdict_valid, 0);
    link_up = 1'b1; g_fill(8'h11); put_k(3, 8'hFD); pads_from(4); cycle();
    check("R1 link drop closed packet", frame_err, 1);

    for (int n = 0; n < 3000; n++) begin
      int r;
      if ($urandom % 6 == 0) g_fill(8'h00);
      else begin
        g_fill(8'h11);
        for (int i = 0; i < NL; i++) begin
          r = $urandom % 16;
          case (r)
            0, 1, 2, 3: sym_data[i*8 +: 8] = 8'($urandom);
            4, 5, 6:    sym_data[i*8 +: 8] = 8'h00;
            7:  put_k(i, 8'hFB);
            8:  put_k(i, 8'h5C);
            9:  put_k(i, 8'hFD);
            10: put_k(i, 8'hFE);
            11, 12: put_k(i, 8'hF7);
            13: put_k(i, 8'hBC);
            default: ;
          endcase
          dec_err[i]  = ($urandom % 40 == 0);
          disp_err[i] = ($urandom % 40 == 0);
        end
      end
      grp_valid = ($urandom % 10 != 0);
      link_up   = ($urandom % 60 != 0);
      cycle();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule